// File: doc/BRIEF.md
# Trap and Return Privilege Controller

This block holds the privileged control state of a small 32-bit RISC-V core. That state is the current privilege level, the interrupt-enable and previous-privilege status bits, and the exception PC, cause and trap-value registers for the Machine and Supervisor levels. The core raises a trap request with its kind (interrupt or exception), cause code, faulting PC, an optional information word and the target privilege, which is already decided by the delegation logic. The core can instead raise a machine-return or supervisor-return request. In the same cycle the block presents the redirect PC. It updates its registers on the next clock edge.

For a trap, the redirect PC comes from the trap-vector base of the target level. The base and mode are supplied as inputs, because the CSR write path sits outside this block. An invalid vector mode raises an error flag. For a return, the redirect PC is the saved exception PC of the returning level with its low bits masked according to whether compressed instructions are enabled. Every return that is taken also pulses a reservation-cancel output in the request cycle, so that an outstanding load-reserved is dropped.

Top module: `trap_ret_ctrl`

## Requirements
- R1: Privilege encoding is User=2'b00, Supervisor=2'b01, Machine=2'b11. A trap sets the privilege to Supervisor when `trap_tgt_i` is 2'b01, and to Machine for any other target code. After reset the privilege is Machine and all status bits and trap registers are zero.
- R2: For an exception with `trap_info_vld_i` high, the target level's tval receives `trap_info_i`. Without a valid info word, tval receives zero.
- R3: For an interrupt, tval is zero whatever the info inputs carry. The target cause register is `{irq, zeros, cause}`, so bit 31 is set only for interrupts.
- R4: The trap redirect PC uses the target level's vector input. Bits [1:0] are the mode and the remaining bits, with [1:0] cleared, are the base. Mode 0 gives the base. Mode 1 gives base + 4*cause for interrupts and the base alone for exceptions.
- R5: Vector modes 2 and 3 raise `vec_err_o` in the request cycle, and the redirect PC is then the base.
- R6: A supervisor return sets SIE to the old SPIE and SPIE to 1. It sets the privilege to Supervisor if SPP is 1 and to User otherwise, then clears SPP.
- R7: `resv_cancel_o` is high in exactly the cycles where a return is taken. It stays low for a trap and when the block is idle.
- R8: A Machine-level trap copies MIE to MPIE, clears MIE, records the prior privilege in MPP and writes the trap PC to mepc.
- R9: A machine return sets MIE to the old MPIE and MPIE to 1, loads the privilege from MPP, and resets MPP to User.
- R10: A Supervisor-level trap copies SIE to SPIE, clears SIE, sets SPP to 1 unless the prior privilege was User, and writes sepc. The Machine trap registers are left unchanged.
- R11: The return redirect PC is the returning level's epc with bit 0 cleared when `rvc_en_i` is high, and bits [1:0] cleared when it is low.
- R12: A trap takes priority over a machine return, which takes priority over a supervisor return. `next_pc_vld_o` is high in any cycle where one of them is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rvc_en_i | input | 1 | Compressed instructions enabled |
| mtvec_i | input | 32 | Machine trap-vector base and mode |
| stvec_i | input | 32 | Supervisor trap-vector base and mode |
| trap_vld_i | input | 1 | Trap request |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_cause_i | input | 5 | Cause code |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| trap_info_vld_i | input | 1 | Info word present |
| trap_info_i | input | 32 | Info word, such as a faulting address |
| trap_tgt_i | input | 2 | Target privilege chosen by delegation |
| mret_i | input | 1 | Machine return request |
| sret_i | input | 1 | Supervisor return request |
| next_pc_vld_o | output | 1 | Redirect is valid |
| next_pc_o | output | 32 | Redirect PC |
| vec_err_o | output | 1 | Invalid vector mode on a trap |
| resv_cancel_o | output | 1 | Cancel load reservation |
| priv_o | output | 2 | Current privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous interrupt enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mepc_o | output | 32 | Machine exception PC |
| mcause_o | output | 32 | Machine cause |
| mtval_o | output | 32 | Machine trap value |
| sepc_o | output | 32 | Supervisor exception PC |
| scause_o | output | 32 | Supervisor cause |
| stval_o | output | 32 | Supervisor trap value |

## Verification
The vector table covers exceptions and interrupts against both target levels under all four vector modes, with and without an info word. This separates the vectored offset from the direct base, and the zeroed trap value from the captured one. Directed sequences walk a double machine return and a double supervisor return. These show that the privilege comes from the saved previous-privilege field and that the enable bits move through the previous-enable bits, under both alignment masks. Simultaneous trap-and-return and machine-and-supervisor-return requests expose the priority order. A Supervisor trap after a Machine trap shows that the Machine registers are left alone.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TRAP = 2'd1,
    OP_MRET = 2'd2,
    OP_SRET = 2'd3
  } op_e;

  typedef struct packed {
    logic  mie;
    logic  mpie;
    priv_e mpp;
    logic  sie;
    logic  spie;
    logic  spp;
  } stat_t;

  localparam int unsigned NLVL  = 2;
  localparam int unsigned LVL_M = 0;
  localparam int unsigned LVL_S = 1;
endpackage

// File: rtl/trap_op_sel.sv
module trap_op_sel
  import trap_pkg::*;
(
  input  logic       trap_i,
  input  logic       mret_i,
  input  logic       sret_i,
  input  logic [1:0] tgt_i,
  output op_e        op_o,
  output logic       tgt_s_o
);
  always_comb begin
    if (trap_i)      op_o = OP_TRAP;
    else if (mret_i) op_o = OP_MRET;
    else if (sret_i) op_o = OP_SRET;
    else             op_o = OP_NONE;
  end

  // only S is honoured as a lower target; anything else lands in M
  assign tgt_s_o = (tgt_i == PRIV_S);
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               err_o
);
  localparam int unsigned PAD_W = XLEN - CAUSE_W - 2;

  logic [1:0]      mode;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  assign mode = tvec_i[1:0];
  assign base = {tvec_i[XLEN-1:2], 2'b00};
  assign offs = {{PAD_W{1'b0}}, cause_i, 2'b00};

  always_comb begin
    err_o = 1'b0;
    pc_o  = base;
    unique case (mode)
      2'd0: pc_o = base;
      2'd1: pc_o = irq_i ? base + offs : base;
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/xret_pc_mask.sv
module xret_pc_mask #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] epc_i,
  input  logic            rvc_en_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] mask;

  assign mask = rvc_en_i ? {{(XLEN-1){1'b1}}, 1'b0} : {{(XLEN-2){1'b1}}, 2'b00};
  assign pc_o = epc_i & mask;
endmodule

// File: rtl/priv_status.sv
module priv_status
  import trap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  op_e   op_i,
  input  logic  tgt_s_i,
  output priv_e priv_o,
  output stat_t stat_o
);
  priv_e priv_q;
  stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;
      stat_q <= '{mie: 1'b0, mpie: 1'b0, mpp: PRIV_U, sie: 1'b0, spie: 1'b0, spp: 1'b0};
    end else begin
      unique case (op_i)
        OP_TRAP: begin
          if (tgt_s_i) begin
            stat_q.spie <= stat_q.sie;
            stat_q.sie  <= 1'b0;
            stat_q.spp  <= (priv_q != PRIV_U);
            priv_q      <= PRIV_S;
          end else begin
            stat_q.mpie <= stat_q.mie;
            stat_q.mie  <= 1'b0;
            stat_q.mpp  <= priv_q;
            priv_q      <= PRIV_M;
          end
        end
        OP_MRET: begin
          stat_q.mie  <= stat_q.mpie;
          stat_q.mpie <= 1'b1;
          stat_q.mpp  <= PRIV_U;
          priv_q      <= stat_q.mpp;
        end
        OP_SRET: begin
          stat_q.sie  <= stat_q.spie;
          stat_q.spie <= 1'b1;
          stat_q.spp  <= 1'b0;
          priv_q      <= stat_q.spp ? PRIV_S : PRIV_U;
        end
        default: ;
      endcase
    end
  end

  assign priv_o = priv_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               info_vld_i,
  input  logic [XLEN-1:0]    info_i,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    cause_o,
  output logic [XLEN-1:0]    tval_o
);
  localparam int unsigned MID_W = XLEN - 1 - CAUSE_W;

  logic [XLEN-1:0] epc_q, cause_q, tval_q;
  logic [XLEN-1:0] tval_d;

  // interrupts never carry a trap value
  assign tval_d = (info_vld_i && !irq_i) ? info_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (we_i) begin
      epc_q   <= pc_i;
      cause_q <= {irq_i, {MID_W{1'b0}}, cause_i};
      tval_q  <= tval_d;
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;
  assign tval_o  = tval_q;
endmodule

// File: rtl/trap_ret_ctrl.sv
module trap_ret_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rvc_en_i,
  input  logic [XLEN-1:0]    mtvec_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic               trap_vld_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic               trap_info_vld_i,
  input  logic [XLEN-1:0]    trap_info_i,
  input  logic [1:0]         trap_tgt_i,
  input  logic               mret_i,
  input  logic               sret_i,
  output logic               next_pc_vld_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               vec_err_o,
  output logic               resv_cancel_o,
  output logic [1:0]         priv_o,
  output logic               mie_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    stval_o
);
  op_e             op;
  logic            tgt_s;
  priv_e           priv;
  stat_t           stat;
  logic [XLEN-1:0] tvec_sel, vec_pc, ret_epc, ret_pc;
  logic            vec_err;

  logic [NLVL-1:0] bank_we;
  logic [XLEN-1:0] epc_l   [NLVL];
  logic [XLEN-1:0] cause_l [NLVL];
  logic [XLEN-1:0] tval_l  [NLVL];

  trap_op_sel u_op (
    .trap_i  (trap_vld_i),
    .mret_i  (mret_i),
    .sret_i  (sret_i),
    .tgt_i   (trap_tgt_i),
    .op_o    (op),
    .tgt_s_o (tgt_s)
  );

  priv_status u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .tgt_s_i (tgt_s),
    .priv_o  (priv),
    .stat_o  (stat)
  );

  assign tvec_sel = tgt_s ? stvec_i : mtvec_i;

  trap_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tvec_i  (tvec_sel),
    .irq_i   (trap_irq_i),
    .cause_i (trap_cause_i),
    .pc_o    (vec_pc),
    .err_o   (vec_err)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_bank
    assign bank_we[l] = (op == OP_TRAP) && ((l == LVL_S) ? tgt_s : !tgt_s);

    trap_csr_bank #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (bank_we[l]),
      .pc_i       (trap_pc_i),
      .irq_i      (trap_irq_i),
      .cause_i    (trap_cause_i),
      .info_vld_i (trap_info_vld_i),
      .info_i     (trap_info_i),
      .epc_o      (epc_l[l]),
      .cause_o    (cause_l[l]),
      .tval_o     (tval_l[l])
    );
  end

  assign ret_epc = (op == OP_SRET) ? epc_l[LVL_S] : epc_l[LVL_M];

  xret_pc_mask #(.XLEN(XLEN)) u_mask (
    .epc_i    (ret_epc),
    .rvc_en_i (rvc_en_i),
    .pc_o     (ret_pc)
  );

  always_comb begin
    unique case (op)
      OP_TRAP:          next_pc_o = vec_pc;
      OP_MRET, OP_SRET: next_pc_o = ret_pc;
      default:          next_pc_o = '0;
    endcase
  end

  assign next_pc_vld_o = (op != OP_NONE);
  assign vec_err_o     = (op == OP_TRAP) && vec_err;
  assign resv_cancel_o = (op == OP_MRET) || (op == OP_SRET);

  assign priv_o   = priv;
  assign mie_o    = stat.mie;
  assign mpie_o   = stat.mpie;
  assign mpp_o    = stat.mpp;
  assign sie_o    = stat.sie;
  assign spie_o   = stat.spie;
  assign spp_o    = stat.spp;
  assign mepc_o   = epc_l[LVL_M];
  assign mcause_o = cause_l[LVL_M];
  assign mtval_o  = tval_l[LVL_M];
  assign sepc_o   = epc_l[LVL_S];
  assign scause_o = cause_l[LVL_S];
  assign stval_o  = tval_l[LVL_S];
endmodule

// File: rtl/trap_ret_ctrl_chk.sv
module trap_ret_ctrl_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rvc_en_i,
  input logic [XLEN-1:0]    mtvec_i,
  input logic [XLEN-1:0]    stvec_i,
  input logic               trap_vld_i,
  input logic               trap_irq_i,
  input logic [CAUSE_W-1:0] trap_cause_i,
  input logic [XLEN-1:0]    trap_pc_i,
  input logic               trap_info_vld_i,
  input logic [XLEN-1:0]    trap_info_i,
  input logic [1:0]         trap_tgt_i,
  input logic               mret_i,
  input logic               sret_i,
  input logic               next_pc_vld_o,
  input logic [XLEN-1:0]    next_pc_o,
  input logic               vec_err_o,
  input logic               resv_cancel_o,
  input logic [1:0]         priv_o,
  input logic               mie_o,
  input logic               mpie_o,
  input logic [1:0]         mpp_o,
  input logic               sie_o,
  input logic               spie_o,
  input logic               spp_o,
  input logic [XLEN-1:0]    mepc_o,
  input logic [XLEN-1:0]    mcause_o,
  input logic [XLEN-1:0]    mtval_o,
  input logic [XLEN-1:0]    sepc_o,
  input logic [XLEN-1:0]    scause_o,
  input logic [XLEN-1:0]    stval_o
);
  logic to_s, to_m, xret;
  logic [1:0] mode_sel;
  assign to_s     = trap_vld_i && (trap_tgt_i == 2'b01);
  assign to_m     = trap_vld_i && (trap_tgt_i != 2'b01);
  assign xret     = (mret_i || sret_i) && !trap_vld_i;
  assign mode_sel = to_s ? stvec_i[1:0] : mtvec_i[1:0];

  AST_TRAP_TO_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_s |=> priv_o == 2'b01); // R1
  AST_TRAP_TO_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_m |=> priv_o == 2'b11); // R1
  AST_TVAL_INFO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_m && !trap_irq_i && trap_info_vld_i |=> mtval_o == $past(trap_info_i)); // R2
  AST_IRQ_TVAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_m && trap_irq_i |=> mtval_o == '0 && mcause_o[XLEN-1]); // R3
  AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_i && mode_sel[1] |-> vec_err_o); // R5
  AST_SRET_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sret_i && !mret_i && !trap_vld_i |=> !spp_o && spie_o && sie_o == $past(spie_o)); // R6
  AST_CANCEL_ON_XRET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xret |-> resv_cancel_o); // R7
  AST_CANCEL_ONLY_XRET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_cancel_o |-> xret); // R7
  AST_MTRAP_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_m |=> !mie_o && mpie_o == $past(mie_o) && mepc_o == $past(trap_pc_i)); // R8
  AST_MRET_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i && !trap_vld_i |=> mpp_o == 2'b00 && mpie_o); // R9
  AST_STRAP_KEEPS_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_s |=> $stable(mepc_o) && $stable(mtval_o)); // R10
  AST_XRET_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xret |-> !next_pc_o[0] && (rvc_en_i || !next_pc_o[1])); // R11
  AST_VLD_ANY_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_vld_i || mret_i || sret_i) |-> next_pc_vld_o); // R12
endmodule

bind trap_ret_ctrl trap_ret_ctrl_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/trap_ret_ctrl_test.sv
module trap_ret_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam logic [31:0] MBASE = 32'h0000_1000;
  localparam logic [31:0] SBASE = 32'h0000_2000;

  typedef struct packed {
    logic        irq;
    logic [4:0]  cause;
    logic [1:0]  tgt;
    logic [1:0]  mode;
    logic        info_vld;
    logic [31:0] exp_pc;
    logic        exp_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd2,  2'd3, 2'd0, 1'b1, 32'h0000_1000, 1'b0},
    '{1'b1, 5'd7,  2'd3, 2'd1, 1'b0, 32'h0000_101C, 1'b0},
    '{1'b0, 5'd5,  2'd1, 2'd1, 1'b1, 32'h0000_2000, 1'b0},
    '{1'b1, 5'd9,  2'd1, 2'd1, 1'b1, 32'h0000_2024, 1'b0},
    '{1'b1, 5'd3,  2'd1, 2'd0, 1'b0, 32'h0000_2000, 1'b0},
    '{1'b0, 5'd13, 2'd3, 2'd2, 1'b1, 32'h0000_1000, 1'b1},
    '{1'b1, 5'd11, 2'd3, 2'd3, 1'b0, 32'h0000_1000, 1'b1},
    '{1'b0, 5'd4,  2'd0, 2'd1, 1'b0, 32'h0000_1000, 1'b0},
    '{1'b1, 5'd5,  2'd3, 2'd1, 1'b1, 32'h0000_1014, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rvc_en_i = 1'b1;
  logic [31:0] mtvec_i = MBASE, stvec_i = SBASE;
  logic trap_vld_i = 1'b0, trap_irq_i = 1'b0, trap_info_vld_i = 1'b0;
  logic [4:0] trap_cause_i = '0;
  logic [31:0] trap_pc_i = '0, trap_info_i = '0;
  logic [1:0] trap_tgt_i = 2'b11;
  logic mret_i = 1'b0, sret_i = 1'b0;
  logic next_pc_vld_o, vec_err_o, resv_cancel_o;
  logic [31:0] next_pc_o;
  logic [1:0] priv_o, mpp_o;
  logic mie_o, mpie_o, sie_o, spie_o, spp_o;
  logic [31:0] mepc_o, mcause_o, mtval_o, sepc_o, scause_o, stval_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trap_ret_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    trap_vld_i = 1'b0; trap_irq_i = 1'b0; trap_info_vld_i = 1'b0;
    mret_i = 1'b0; sret_i = 1'b0;
  endtask

  // clock the request in, then drop it on the next falling edge
  task automatic step();
    @(posedge clk_i); #1;
    @(negedge clk_i); clr();
  endtask

  task automatic set_trap(input logic irq, input logic [4:0] c, input logic [1:0] tgt,
                          input logic [31:0] pc, input logic iv, input logic [31:0] info);
    trap_vld_i = 1'b1; trap_irq_i = irq; trap_cause_i = c; trap_tgt_i = tgt;
    trap_pc_i = pc; trap_info_vld_i = iv; trap_info_i = info;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; clr();
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur;
    do_reset();
    // R1 reset state
    chk("R1 reset priv", 32'(priv_o), 32'h3);
    chk("R1 reset status", {26'd0, mie_o, mpie_o, mpp_o, sie_o, spie_o}, 32'h0);
    chk("R1 reset regs", mepc_o | mtval_o | sepc_o | scause_o, 32'h0);
    chk("R7 idle cancel", 32'(resv_cancel_o), 32'h0);
    chk("R12 idle vld", 32'(next_pc_vld_o), 32'h0);

    cur = 2'b11;
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc, info, exp_tval, exp_cause;
      logic [1:0] exp_priv;
      pc   = 32'h8000_0100 + 32'(i * 4);
      info = 32'hDEAD_0000 + 32'(i);
      @(negedge clk_i);
      mtvec_i = MBASE | 32'(VECS[i].mode);
      stvec_i = SBASE | 32'(VECS[i].mode);
      set_trap(VECS[i].irq, VECS[i].cause, VECS[i].tgt, pc, VECS[i].info_vld, info);
      #1;
      chk("R4 vector pc", next_pc_o, VECS[i].exp_pc);
      chk("R5 vector err", 32'(vec_err_o), 32'(VECS[i].exp_err));
      chk("R7 no cancel on trap", 32'(resv_cancel_o), 32'h0);
      step();
      exp_priv  = (VECS[i].tgt == 2'b01) ? 2'b01 : 2'b11;
      exp_tval  = (VECS[i].irq || !VECS[i].info_vld) ? 32'h0 : info;
      exp_cause = {VECS[i].irq, 26'd0, VECS[i].cause};
      chk("R1 trap priv", 32'(priv_o), 32'(exp_priv));
      if (exp_priv == 2'b01) begin
        chk("R2 R3 stval", stval_o, exp_tval);
        chk("R3 scause", scause_o, exp_cause);
        chk("R10 sepc", sepc_o, pc);
        chk("R10 spp", 32'(spp_o), 32'(cur != 2'b00));
      end else begin
        chk("R2 R3 mtval", mtval_o, exp_tval);
        chk("R3 mcause", mcause_o, exp_cause);
        chk("R8 mepc", mepc_o, pc);
        chk("R8 mpp", 32'(mpp_o), 32'(cur));
      end
      cur = exp_priv;
    end

    do_reset();
    mtvec_i = MBASE; stvec_i = SBASE | 32'h1;
    // R8 trap from M
    @(negedge clk_i); set_trap(1'b0, 5'd2, 2'b11, 32'h8000_0103, 1'b0, 32'h1234);
    step();
    chk("R8 mepc", mepc_o, 32'h8000_0103);
    chk("R8 mpp=M", 32'(mpp_o), 32'h3);
    chk("R2 no info tval", mtval_o, 32'h0);
    // R9 first MRET, rvc on
    @(negedge clk_i); rvc_en_i = 1'b1; mret_i = 1'b1; #1;
    chk("R11 mret pc rvc", next_pc_o, 32'h8000_0102);
    chk("R7 mret cancel", 32'(resv_cancel_o), 32'h1);
    chk("R12 mret vld", 32'(next_pc_vld_o), 32'h1);
    step();
    chk("R9 priv from mpp", 32'(priv_o), 32'h3);
    chk("R9 mie/mpie/mpp", {28'd0, mie_o, mpie_o, mpp_o}, 32'h4);
    // second MRET, rvc off
    @(negedge clk_i); rvc_en_i = 1'b0; mret_i = 1'b1; #1;
    chk("R11 mret pc norvc", next_pc_o, 32'h8000_0100);
    step();
    chk("R9 priv U", 32'(priv_o), 32'h0);
    chk("R9 mie set", {30'd0, mie_o, mpie_o}, 32'h3);
    rvc_en_i = 1'b1;
    // R8 trap from U with MIE=1
    @(negedge clk_i); set_trap(1'b0, 5'd8, 2'b11, 32'h0000_0200, 1'b0, 32'h0);
    step();
    chk("R8 mie->mpie", {28'd0, mie_o, mpie_o, mpp_o}, 32'h4);
    chk("R8 priv M", 32'(priv_o), 32'h3);
    // R10 trap to S from M, vectored irq
    @(negedge clk_i); set_trap(1'b1, 5'd1, 2'b01, 32'h4000_0006, 1'b1, 32'hFFFF);
    #1; chk("R4 S vectored", next_pc_o, 32'h0000_2004);
    step();
    chk("R10 priv S", 32'(priv_o), 32'h1);
    chk("R10 spp/spie/sie", {29'd0, spp_o, spie_o, sie_o}, 32'h4);
    chk("R10 mepc kept", mepc_o, 32'h0000_0200);
    chk("R3 scause irq", scause_o, 32'h8000_0001);
    chk("R3 stval zero", stval_o, 32'h0);
    // R6 SRET twice
    @(negedge clk_i); sret_i = 1'b1; #1;
    chk("R11 sret pc", next_pc_o, 32'h4000_0006);
    chk("R7 sret cancel", 32'(resv_cancel_o), 32'h1);
    step();
    chk("R6 priv S", 32'(priv_o), 32'h1);
    chk("R6 spp/spie/sie", {29'd0, spp_o, spie_o, sie_o}, 32'h2);
    @(negedge clk_i); sret_i = 1'b1;
    step();
    chk("R6 priv U", 32'(priv_o), 32'h0);
    chk("R6 sie from spie", {29'd0, spp_o, spie_o, sie_o}, 32'h3);
    // R10 trap to S from U
    @(negedge clk_i); set_trap(1'b0, 5'd12, 2'b01, 32'h0000_0300, 1'b1, 32'h0000_ABCD);
    step();
    chk("R10 spp from U", {29'd0, spp_o, spie_o, sie_o}, 32'h2);
    chk("R2 stval info", stval_o, 32'h0000_ABCD);
    // R12 trap beats MRET
    @(negedge clk_i); set_trap(1'b0, 5'd3, 2'b11, 32'h0000_0500, 1'b0, 32'h0); mret_i = 1'b1; #1;
    chk("R12 trap wins pc", next_pc_o, 32'h0000_1000);
    chk("R12 trap wins cancel", 32'(resv_cancel_o), 32'h0);
    step();
    chk("R12 trap wins priv", 32'(priv_o), 32'h3);
    chk("R12 trap wins mpp", 32'(mpp_o), 32'h1);
    // R12 MRET beats SRET
    @(negedge clk_i); mret_i = 1'b1; sret_i = 1'b1; #1;
    chk("R12 mret wins pc", next_pc_o, 32'h0000_0500);
    step();
    chk("R12 mret wins priv", 32'(priv_o), 32'h1);
    chk("R12 sret ignored", {30'd0, sie_o, spie_o}, 32'h1);
    #1;
    chk("R7 idle after", 32'(resv_cancel_o), 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule